// File: doc/BRIEF.md
# Two-Port Snooping Cache System with Write-Through Invalidation

The block joins two processor ports to one word-addressed backing memory over a single shared bus. Each port has its own direct-mapped cache of one-word lines. Coherence is kept by a two-state scheme. A line is either Invalid or Valid. Every processor write goes through to memory, and any other cache holding that word drops its copy.

A processor pulses its request together with the operation, address and write data. It then waits for a one-cycle done pulse that carries the read data. It issues nothing further until that pulse arrives. Reads that hit complete locally in one cycle. Read misses and all writes arbitrate for the bus, which grants one whole transaction at a time. Because of this, the order on the bus is the single order in which writes and invalidations take effect. The bus owner, the operation and the address are visible at the ports so that traffic can be observed.

An address is split into an index, which is the low `IDX_W` bits, and a tag, which is the remaining upper bits. Addresses with equal low bits compete for the same line.

Top module: `wt_snoop_sys`

## Requirements
- R1: After reset every line of both caches is Invalid, memory holds zero, no done pulse is raised and the bus is idle. The first read of any address therefore uses the bus and returns 0.
- R2: A read whose line is Invalid or holds another tag issues one bus read. It fills the line with the tag and the memory word and returns that word. The done pulse comes MEM_LAT+2 cycles after the request edge when the bus is free.
- R3: A read whose line is Valid with a matching tag returns the cached word with done one cycle after the request edge. It causes no bus transaction.
- R4: Every write issues one bus write that updates memory, with done 3 cycles after the request edge when the bus is free. The writer's own line keeps its Valid/Invalid state, and a write miss allocates nothing. On a write hit the local copy takes the new word.
- R5: A write to an address that shares an index with the writer's resident Valid line but has another tag leaves that line's tag and data unchanged. A later read of the resident address still hits.
- R6: A bus write by one port invalidates the other cache's line if that line is Valid with the same tag. A line holding another tag is left alone.
- R7: When both ports request in the same cycle, the grant goes to the port that was not granted last. After reset port 0 has priority. A grant is held, with owner and address stable, until its memory access completes.
- R8: Two writes to one address issued together reach memory in grant order. Afterwards both ports read the later-granted value.
- R9: A bus write completes in its first bus cycle. A bus read completes after MEM_LAT bus cycles. Memory signals completion only while the bus is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p0_req | input | 1 | Port 0 request pulse |
| p0_we | input | 1 | Port 0 operation: 1 write, 0 read |
| p0_addr | input | ADDR_W | Port 0 word address |
| p0_wdata | input | DATA_W | Port 0 write data |
| p0_done | output | 1 | Port 0 completion pulse |
| p0_rdata | output | DATA_W | Port 0 read data, valid with done |
| p1_req | input | 1 | Port 1 request pulse |
| p1_we | input | 1 | Port 1 operation: 1 write, 0 read |
| p1_addr | input | ADDR_W | Port 1 word address |
| p1_wdata | input | DATA_W | Port 1 write data |
| p1_done | output | 1 | Port 1 completion pulse |
| p1_rdata | output | DATA_W | Port 1 read data, valid with done |
| bus_busy | output | 1 | A bus transaction is in progress |
| bus_owner | output | 1 | Port holding the bus grant |
| bus_we | output | 1 | Current bus transaction is a write |
| bus_addr | output | ADDR_W | Current bus address |

## Verification
The assertions rely on each processor keeping its request low from the request edge until its done pulse. Under that condition a cache can never fill from its own read at the same edge as it is invalidated by the other port's write. The stimulus guarantees this because one task drives both ports: it raises a request for exactly one cycle and waits for every started access to complete before issuing the next. The sweep walks every address of the small default configuration. Contention cases are produced only by starting two writes on the same edge, so the arbitration order stays predictable.

// File: rtl/wt_snoop_pkg.sv
package wt_snoop_pkg;

  typedef enum logic [0:0] {
    CTL_IDLE = 1'b0,
    CTL_BUS  = 1'b1
  } ctl_state_e;

  // Round-robin pick between two requesters given the last winner.
  function automatic logic rr_pick(input logic [1:0] req, input logic last);
    if (req == 2'b11) return ~last;
    return req[1];
  endfunction

endpackage

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
  import wt_snoop_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 2,
  parameter int PORT_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              breq,
  output logic              bwe,
  output logic [ADDR_W-1:0] baddr,
  output logic [DATA_W-1:0] bwdata,
  input  logic              bus_done,
  input  logic              bus_owner,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [(1<<IDX_W)-1:0] vmask,
  output logic              probe
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;
  localparam logic ME  = 1'(PORT_ID);

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  ctl_state_e        st;
  logic              op_we;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata;
  logic [LINES-1:0]  valid;
  logic [TAG_W-1:0]  tags [LINES];
  logic [DATA_W-1:0] data [LINES];

  logic [IDX_W-1:0] req_idx, op_idx, snp_idx;
  logic             lookup_hit, op_hit, my_done, snoop_kill;

  always_comb begin
    req_idx    = idx_of(addr);
    op_idx     = idx_of(op_addr);
    snp_idx    = idx_of(bus_addr);
    lookup_hit = valid[req_idx] && (tags[req_idx] == tag_of(addr));
    op_hit     = valid[op_idx] && (tags[op_idx] == tag_of(op_addr));
    probe      = valid[snp_idx] && (tags[snp_idx] == tag_of(bus_addr));
    my_done    = bus_done && (bus_owner == ME);
    snoop_kill = bus_done && bus_we && (bus_owner != ME) && probe;
  end

  assign breq   = (st == CTL_BUS);
  assign bwe    = op_we;
  assign baddr  = op_addr;
  assign bwdata = op_wdata;
  assign vmask  = valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= CTL_IDLE;
      op_we    <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
      valid    <= '0;
      done     <= 1'b0;
      rdata    <= '0;
      for (int i = 0; i < LINES; i++) begin
        tags[i] <= '0;
        data[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      if (snoop_kill) valid[snp_idx] <= 1'b0;
      case (st)
        CTL_IDLE: begin
          if (req) begin
            op_we    <= we;
            op_addr  <= addr;
            op_wdata <= wdata;
            if (!we && lookup_hit) begin
              done  <= 1'b1;
              rdata <= data[req_idx];
            end else begin
              st <= CTL_BUS;
            end
          end
        end
        default: begin
          if (my_done) begin
            st   <= CTL_IDLE;
            done <= 1'b1;
            if (!op_we) begin
              valid[op_idx] <= 1'b1;
              tags[op_idx]  <= tag_of(op_addr);
              data[op_idx]  <= bus_rdata;
              rdata         <= bus_rdata;
            end else begin
              rdata <= op_wdata;
              if (op_hit) data[op_idx] <= op_wdata;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/wt_snoop_arb.sv
module wt_snoop_arb
  import wt_snoop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] breq,
  input  logic       bus_done,
  output logic       busy,
  output logic       owner
);
  logic last;
  logic grant_ev;
  logic pick;

  always_comb begin
    grant_ev = !busy && (|breq);
    pick     = rr_pick(breq, last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= 1'b0;
      last  <= 1'b1;
    end else if (grant_ev) begin
      busy  <= 1'b1;
      owner <= pick;
      last  <= pick;
    end else if (bus_done) begin
      busy <= 1'b0;
    end
  end

endmodule

// File: rtl/wt_snoop_mem.sv
module wt_snoop_mem #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int MEM_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int CNT_W = $clog2(MEM_LAT + 1);
  localparam logic [CNT_W-1:0] LAT_M1 = CNT_W'(MEM_LAT - 1);

  logic [DATA_W-1:0] mem [WORDS];
  logic [CNT_W-1:0]  cnt;

  assign done  = busy && (we || (cnt == LAT_M1));
  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      if (done) cnt <= '0;
      else if (busy) cnt <= cnt + 1'b1;
      if (done && we) mem[addr] <= wdata;
    end
  end

endmodule

// File: rtl/wt_snoop_sys.sv
module wt_snoop_sys #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 2,
  parameter int MEM_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p0_req,
  input  logic              p0_we,
  input  logic [ADDR_W-1:0] p0_addr,
  input  logic [DATA_W-1:0] p0_wdata,
  output logic              p0_done,
  output logic [DATA_W-1:0] p0_rdata,
  input  logic              p1_req,
  input  logic              p1_we,
  input  logic [ADDR_W-1:0] p1_addr,
  input  logic [DATA_W-1:0] p1_wdata,
  output logic              p1_done,
  output logic [DATA_W-1:0] p1_rdata,
  output logic              bus_busy,
  output logic              bus_owner,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr
);
  localparam int LINES = 1 << IDX_W;
  localparam int NPORT = 2;

  logic              pr_req   [NPORT];
  logic              pr_we    [NPORT];
  logic [ADDR_W-1:0] pr_addr  [NPORT];
  logic [DATA_W-1:0] pr_wdata [NPORT];
  logic              pr_done  [NPORT];
  logic [DATA_W-1:0] pr_rdata [NPORT];
  logic              bq       [NPORT];
  logic              bw       [NPORT];
  logic [ADDR_W-1:0] ba       [NPORT];
  logic [DATA_W-1:0] bd       [NPORT];
  logic [LINES-1:0]  vm       [NPORT];
  logic              pb       [NPORT];

  // Named internal events for the checker.
  logic [1:0]        breq_v;
  logic              bus_done;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic [IDX_W-1:0]  snoop_idx;
  logic [LINES-1:0]  vm0, vm1;
  logic              pb0, pb1;

  assign pr_req[0] = p0_req;  assign pr_we[0] = p0_we;
  assign pr_addr[0] = p0_addr; assign pr_wdata[0] = p0_wdata;
  assign pr_req[1] = p1_req;  assign pr_we[1] = p1_we;
  assign pr_addr[1] = p1_addr; assign pr_wdata[1] = p1_wdata;
  assign p0_done = pr_done[0]; assign p0_rdata = pr_rdata[0];
  assign p1_done = pr_done[1]; assign p1_rdata = pr_rdata[1];

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    wt_snoop_cache #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .PORT_ID(g)
    ) u_cache (
      .clk(clk), .rst_n(rst_n),
      .req(pr_req[g]), .we(pr_we[g]), .addr(pr_addr[g]), .wdata(pr_wdata[g]),
      .done(pr_done[g]), .rdata(pr_rdata[g]),
      .breq(bq[g]), .bwe(bw[g]), .baddr(ba[g]), .bwdata(bd[g]),
      .bus_done(bus_done), .bus_owner(bus_owner), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_rdata(bus_rdata),
      .vmask(vm[g]), .probe(pb[g])
    );
  end

  assign breq_v    = {bq[1], bq[0]};
  assign bus_we    = bw[bus_owner];
  assign bus_addr  = ba[bus_owner];
  assign bus_wdata = bd[bus_owner];
  assign snoop_idx = bus_addr[IDX_W-1:0];
  assign vm0 = vm[0];
  assign vm1 = vm[1];
  assign pb0 = pb[0];
  assign pb1 = pb[1];

  wt_snoop_arb u_arb (
    .clk(clk), .rst_n(rst_n), .breq(breq_v), .bus_done(bus_done),
    .busy(bus_busy), .owner(bus_owner)
  );

  wt_snoop_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_LAT(MEM_LAT)) u_mem (
    .clk(clk), .rst_n(rst_n), .busy(bus_busy), .we(bus_we),
    .addr(bus_addr), .wdata(bus_wdata), .done(bus_done), .rdata(bus_rdata)
  );

endmodule

// File: rtl/wt_snoop_checker.sv
module wt_snoop_checker #(
  parameter int ADDR_W = 4,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_busy,
  input logic              bus_owner,
  input logic              bus_we,
  input logic              bus_done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [IDX_W-1:0]  snoop_idx,
  input logic [1:0]        breq_v,
  input logic [(1<<IDX_W)-1:0] vm0,
  input logic [(1<<IDX_W)-1:0] vm1,
  input logic              pb0,
  input logic              pb1
);

  assert_grant_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy && !bus_done |=> bus_busy && $stable(bus_owner) && $stable(bus_addr));

  assert_grant_to_requester_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> breq_v[bus_owner]);

  assert_write_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy && bus_we |-> bus_done);

  assert_done_only_granted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done |-> bus_busy);

  assert_snoop_kill_c1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done && bus_we && !bus_owner && pb1 |=> !vm1[$past(snoop_idx)]);

  assert_snoop_kill_c0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done && bus_we && bus_owner && pb0 |=> !vm0[$past(snoop_idx)]);

  assert_own_write_keeps_c0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done && bus_we && !bus_owner |=> vm0 == $past(vm0));

  assert_own_write_keeps_c1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_done && bus_we && bus_owner |=> vm1 == $past(vm1));

endmodule

bind wt_snoop_sys wt_snoop_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_busy(bus_busy), .bus_owner(bus_owner),
  .bus_we(bus_we), .bus_done(bus_done), .bus_addr(bus_addr),
  .snoop_idx(snoop_idx), .breq_v(breq_v), .vm0(vm0), .vm1(vm1),
  .pb0(pb0), .pb1(pb1)
);

// File: tb/wt_snoop_sys_test.sv
`timescale 1ns/1ps
module wt_snoop_sys_test;
  localparam int AW = 4, DW = 8, IW = 2, LAT = 2;
  localparam int NA = 1 << AW, NL = 1 << IW;

  logic clk = 0, rst_n = 0;
  logic p0_req = 0, p0_we = 0, p1_req = 0, p1_we = 0;
  logic [AW-1:0] p0_addr = 0, p1_addr = 0;
  logic [DW-1:0] p0_wdata = 0, p1_wdata = 0;
  logic p0_done, p1_done, bus_busy, bus_owner, bus_we;
  logic [DW-1:0] p0_rdata, p1_rdata;
  logic [AW-1:0] bus_addr;

  wt_snoop_sys #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .MEM_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n),
    .p0_req(p0_req), .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata),
    .p0_done(p0_done), .p0_rdata(p0_rdata),
    .p1_req(p1_req), .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata),
    .p1_done(p1_done), .p1_rdata(p1_rdata),
    .bus_busy(bus_busy), .bus_owner(bus_owner), .bus_we(bus_we), .bus_addr(bus_addr));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, txn = 0;
  bit busy_q = 0, finished = 0;

  always @(negedge clk) begin
    if (bus_busy && !busy_q) txn++;
    busy_q = bus_busy;
  end

  // Reference model of the requirements.
  logic [DW-1:0] mm [NA];
  bit            vv [2][NL];
  logic [AW-IW-1:0] tt [2][NL];
  logic [DW-1:0] dd [2][NL];
  bit            last_g = 1;

  function automatic bit m_hit(int p, logic [AW-1:0] a);
    return vv[p][a[IW-1:0]] && tt[p][a[IW-1:0]] == a[AW-1:IW];
  endfunction

  task automatic m_write(int p, logic [AW-1:0] a, logic [DW-1:0] d);
    mm[a] = d;
    if (m_hit(p, a)) dd[p][a[IW-1:0]] = d;
    if (m_hit(1-p, a)) vv[1-p][a[IW-1:0]] = 0;
    last_g = p[0];
  endtask

  task automatic check(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic run2(input bit e0, w0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                      input bit e1, w1, input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                      output int c0, c1, output logic [DW-1:0] r0, r1);
    bit g0, g1;
    int n;
    @(negedge clk);
    p0_req = e0; p0_we = w0; p0_addr = a0; p0_wdata = d0;
    p1_req = e1; p1_we = w1; p1_addr = a1; p1_wdata = d1;
    g0 = !e0; g1 = !e1; n = 0; c0 = 0; c1 = 0; r0 = 0; r1 = 0;
    while (!(g0 && g1) && n < 100) begin
      @(posedge clk); n++;
      @(negedge clk); p0_req = 0; p1_req = 0;
      if (!g0 && p0_done) begin g0 = 1; c0 = n; r0 = p0_rdata; end
      if (!g1 && p1_done) begin g1 = 1; c1 = n; r1 = p1_rdata; end
    end
    check(g0 && g1, "R2", "access completion", int'(g0) + int'(g1), 2);
  endtask

  // One access on one port, checked against the model.
  task automatic op(int p, bit w, logic [AW-1:0] a, logic [DW-1:0] d, string rq);
    int c0, c1, cyc, t0, ecyc, etx;
    logic [DW-1:0] r0, r1, r, ed;
    bit h;
    h = !w && m_hit(p, a);
    ecyc = w ? 3 : (h ? 1 : LAT + 2);
    etx = h ? 0 : 1;
    ed = w ? d : (h ? dd[p][a[IW-1:0]] : mm[a]);
    t0 = txn;
    if (p == 0) run2(1, w, a, d, 0, 0, 0, 0, c0, c1, r0, r1);
    else        run2(0, 0, 0, 0, 1, w, a, d, c0, c1, r0, r1);
    cyc = (p == 0) ? c0 : c1;
    r   = (p == 0) ? r0 : r1;
    check(cyc == ecyc, rq, "latency", cyc, ecyc);
    check(txn - t0 == etx, rq, "bus transactions", txn - t0, etx);
    if (!w) check(r == ed, rq, "read data", int'(r), int'(ed));
    if (w) m_write(p, a, d);
    else if (!h) begin
      vv[p][a[IW-1:0]] = 1; tt[p][a[IW-1:0]] = a[AW-1:IW]; dd[p][a[IW-1:0]] = mm[a];
      last_g = p[0];
    end
  endtask

  // Two writes issued together.
  task automatic dual_wr(logic [AW-1:0] a0, logic [DW-1:0] d0,
                         logic [AW-1:0] a1, logic [DW-1:0] d1, string rq);
    int c0, c1, win;
    logic [DW-1:0] r0, r1;
    win = last_g ? 0 : 1;
    run2(1, 1, a0, d0, 1, 1, a1, d1, c0, c1, r0, r1);
    check((win == 0 ? c0 : c1) == 3, rq, "first grant latency", win == 0 ? c0 : c1, 3);
    check((win == 0 ? c1 : c0) == 5, rq, "second grant latency", win == 0 ? c1 : c0, 5);
    if (win == 0) begin m_write(0, a0, d0); m_write(1, a1, d1); end
    else          begin m_write(1, a1, d1); m_write(0, a0, d0); end
  endtask

  localparam logic [AW-1:0] A1 = 4'd1, A2 = 4'd5;

  initial begin
    for (int i = 0; i < NA; i++) mm[i] = 0;
    for (int p = 0; p < 2; p++) for (int i = 0; i < NL; i++) begin
      vv[p][i] = 0; tt[p][i] = 0; dd[p][i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: reset state
    check(!p0_done && !p1_done, "R1", "no done after reset", int'(p0_done) + int'(p1_done), 0);
    check(!bus_busy, "R1", "bus idle after reset", int'(bus_busy), 0);
    op(1, 0, 4'd10, 0, "R1");

    // Six-step trace: port 0 plays the first processor, port 1 the second.
    op(0, 1, A1, 8'd10, "R4");
    op(0, 0, A1, 0, "R2");
    check(m_hit(0, A1) && dd[0][1] == 10, "R2", "model fill", int'(dd[0][1]), 10);
    op(0, 0, A1, 0, "R3");
    op(1, 0, A1, 0, "R2");
    op(1, 1, A1, 8'd20, "R6");
    op(1, 1, A2, 8'd40, "R5");
    op(1, 0, A1, 0, "R5");
    op(0, 0, A1, 0, "R6");
    op(0, 0, A2, 0, "R2");

    // Write hit updates the local copy.
    op(0, 0, 4'd13, 0, "R2");
    op(0, 1, 4'd13, 8'h77, "R4");
    op(0, 0, 4'd13, 0, "R4");

    // Sweep every address.
    for (int a = 0; a < NA; a++) begin
      op(0, 1, 4'(a), 8'(a * 7 + 3), "R4");
      op(1, 0, 4'(a), 0, "R2");
      op(1, 0, 4'(a), 0, "R3");
      op(0, 0, 4'(a), 0, "R2");
    end

    // Contention and write serialization.
    op(0, 1, 4'd6, 8'h11, "R7");
    dual_wr(4'd6, 8'h55, 4'd6, 8'hAA, "R7");
    check(mm[6] == 8'h55, "R8", "later grant value", int'(mm[6]), 8'h55);
    op(0, 0, 4'd6, 0, "R8");
    op(1, 0, 4'd6, 0, "R8");
    dual_wr(4'd3, 8'h21, 4'd7, 8'h42, "R7");
    dual_wr(4'd3, 8'h31, 4'd3, 8'h32, "R8");
    op(0, 0, 4'd3, 0, "R8");
    op(1, 0, 4'd3, 0, "R8");
    op(1, 0, 4'd7, 0, "R9");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule